// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block produces the 16x oversampling enable for a serial port, and a bit-rate strobe derived from it. The rate comes from a divisor in 1/64-clock units, with a 16-bit whole part and a 6-bit fraction. Software picks the divisor as clk*64/(16*baud). The overall rate is therefore clk/(16*divisor).

The two divisor halves are written through a small write port into shadow registers. The generator keeps running on its previous divisor until a separate commit write arrives. That write copies both shadows into the active divisor and restarts the timing chain.

Between ticks the generator counts whole clocks. A 6-bit phase accumulator adds the fraction once per oversample period. A carry out of that accumulator lengthens the next period by one clock, so the extra cycles are spread evenly. A divisor outside the legal range stops all ticks and raises an error flag.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted and after it is released, `overTick` and `bitTick` are 0 and `cfgError` is 1, until a legal divisor is committed.
- R2: A write to address 0 (whole part, `wrData[15:0]`) or address 1 (fraction) changes only the shadow registers. The tick spacing stays unchanged until a write to address 2 occurs.
- R3: A write to address 2 copies both shadows into the active divisor and restarts the chain. The first `overTick` is visible during the cycle that follows `D` rising edges, counting the commit edge as the first, where `D` is the whole part.
- R4: For a legal divisor D + F/64, the 64 oversample periods that follow the first tick after a commit total exactly 64*D + F clocks.
- R5: Every spacing between consecutive `overTick` pulses is either D or D+1 clocks.
- R6: An address-1 write keeps only `wrData[5:0]` as the fraction, and the upper data bits are ignored.
- R7: A committed whole part of 0 raises `cfgError` and holds `overTick` and `bitTick` at 0.
- R8: A whole part of 65535 with a nonzero fraction is out of range and raises `cfgError`. A whole part of 65535 with fraction 0 is legal and clears `cfgError`.
- R9: `bitTick` is a one-clock pulse that coincides with every 16th `overTick` after a commit (the 16th, 32nd, and so on) and is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for one cycle |
| wrAddr | input | 2 | 0 = whole-part shadow, 1 = fraction shadow, 2 = commit |
| wrData | input | 16 | Write data |
| overTick | output | 1 | One-clock oversample enable (16x the bit rate) |
| bitTick | output | 1 | One-clock bit-rate strobe |
| cfgError | output | 1 | Active divisor is out of range |

## Verification
The bench builds the generator with its default widths: a 16-bit whole part, a 6-bit fraction and 16x oversampling. Small whole parts (1 to 7) keep each measurement short, so the full 64-period dither cycle can be observed and summed against 64*D+F for several fractions. These include 0, 1, 32 and 63. The 16-bit default also places the upper range limit at 65535, which the bench reaches for the R8 check.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  // Strobes from the control block to the timing datapath
  typedef struct packed {
    logic restart;  // commit write seen this cycle
    logic run;      // active divisor is legal
  } rate_ctl_t;
endpackage

// File: rtl/fbg_ctrl.sv
module fbg_ctrl #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [INT_W-1:0]    divInt,
  output logic [FRAC_W-1:0]   divFrac,
  output fbg_pkg::rate_ctl_t  ctl,
  output logic                cfgError
);
  localparam logic [ADDR_W-1:0] ADDR_INT    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_FRAC   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_COMMIT = ADDR_W'(2);

  logic [INT_W-1:0]  shadowInt;
  logic [FRAC_W-1:0] shadowFrac;
  logic              commitWr;
  logic              legal;

  assign commitWr = wrEn && (wrAddr == ADDR_COMMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowInt  <= '0;
      shadowFrac <= '0;
      divInt     <= '0;
      divFrac    <= '0;
    end else begin
      if (wrEn && wrAddr == ADDR_INT)  shadowInt  <= wrData[INT_W-1:0];
      if (wrEn && wrAddr == ADDR_FRAC) shadowFrac <= wrData[FRAC_W-1:0];
      if (commitWr) begin
        divInt  <= shadowInt;
        divFrac <= shadowFrac;
      end
    end
  end

  // Legal range: 1.0 up to the all-ones whole part with zero fraction
  assign legal    = (|divInt) && !((&divInt) && (|divFrac));
  assign cfgError = !legal;

  assign ctl.restart = commitWr;
  assign ctl.run     = legal;
endmodule

// File: rtl/fbg_dp.sv
module fbg_dp #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int OVS    = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INT_W-1:0]   divInt,
  input  logic [FRAC_W-1:0]  divFrac,
  input  fbg_pkg::rate_ctl_t ctl,
  output logic               overTick,
  output logic               bitTick
);
  localparam int CNT_W = INT_W + 1;
  localparam int BIT_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(OVS - 1);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  target;
  logic [FRAC_W-1:0] phase;
  logic [FRAC_W:0]   phaseSum;
  logic              stretch;
  logic [BIT_W-1:0]  bitCnt;

  assign target   = {1'b0, divInt} + CNT_W'(stretch);
  assign phaseSum = {1'b0, phase} + {1'b0, divFrac};
  assign overTick = ctl.run && (cnt == target);
  assign bitTick  = overTick && (bitCnt == BIT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= CNT_W'(1);
      phase   <= '0;
      stretch <= 1'b0;
      bitCnt  <= '0;
    end else if (ctl.restart || !ctl.run) begin
      cnt     <= CNT_W'(1);
      phase   <= '0;
      stretch <= 1'b0;
      bitCnt  <= '0;
    end else if (overTick) begin
      cnt     <= CNT_W'(1);
      phase   <= phaseSum[FRAC_W-1:0];
      stretch <= phaseSum[FRAC_W];
      bitCnt  <= bitCnt + BIT_W'(1);
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int OVS    = 16,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              overTick,
  output logic              bitTick,
  output logic              cfgError
);
  logic [INT_W-1:0]   divInt;
  logic [FRAC_W-1:0]  divFrac;
  fbg_pkg::rate_ctl_t ctlStrobes;
  logic               commitStrobe;

  assign commitStrobe = ctlStrobes.restart;

  fbg_ctrl #(.INT_W(INT_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .divInt(divInt), .divFrac(divFrac), .ctl(ctlStrobes), .cfgError(cfgError)
  );

  fbg_dp #(.INT_W(INT_W), .FRAC_W(FRAC_W), .OVS(OVS)) u_dp (
    .clk(clk), .rstN(rstN), .divInt(divInt), .divFrac(divFrac), .ctl(ctlStrobes),
    .overTick(overTick), .bitTick(bitTick)
  );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker (
  input logic clk,
  input logic rstN,
  input logic overTick,
  input logic bitTick,
  input logic cfgError,
  input logic commit
);
  // R9
  bit_with_over_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> overTick);

  // R9
  bit_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |=> !bitTick);

  // R7
  err_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> (!overTick && !bitTick));

  // R2
  err_needs_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !commit |=> $stable(cfgError));
endmodule

bind frac_baud_gen fbg_checker u_chk (
  .clk(clk), .rstN(rstN), .overTick(overTick), .bitTick(bitTick),
  .cfgError(cfgError), .commit(commitStrobe)
);

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        overTick, bitTick, cfgError;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // whole part, fraction, expected clocks over 64 periods
  localparam int NV = 6;
  localparam int VEC [0:NV-1][0:2] = '{
    '{1, 0, 64}, '{3, 0, 192}, '{3, 5, 197},
    '{2, 32, 160}, '{5, 63, 383}, '{1, 1, 65}
  };

  frac_baud_gen uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .overTick(overTick), .bitTick(bitTick), .cfgError(cfgError)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Commit is the last write; sampling starts at the negedge after the commit edge
  task automatic runRate(input int di, input int df, input int expSpan);
    int cyc = 0, nTick = 0, lastT = 0, firstT = -1, t65 = -1;
    int badIv = 0, nBit = 0, bitBad = 0;
    forever begin
      if (overTick) begin
        nTick++;
        if (nTick == 1) firstT = cyc;
        else if ((cyc - lastT) != di && (cyc - lastT) != di + 1) badIv++;
        if (bitTick) begin
          nBit++;
          if (nTick % 16 != 0) bitBad++;
        end else if (nTick % 16 == 0) bitBad++;
        lastT = cyc;
        if (nTick == 65) t65 = cyc;
      end else if (bitTick) bitBad++;
      if (nTick >= 65 || cyc > 8000) break;
      @(negedge clk);
      cyc++;
    end
    chk(firstT == di - 1, "R3 first tick", firstT, di - 1);
    chk(t65 - firstT == expSpan, "R4 span", t65 - firstT, expSpan);
    chk(badIv == 0, "R5 spacing", badIv, 0);
    chk(nBit == 4 && bitBad == 0, "R9 bitTick", nBit, 4);
  endtask

  initial begin
    int ticks, prevT, badIv;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!overTick && !bitTick && cfgError, "R1 in reset", {overTick, bitTick, cfgError}, 1);
    rstN = 1'b1;
    ticks = 0;
    repeat (20) begin
      @(negedge clk);
      if (overTick || bitTick || !cfgError) ticks++;
    end
    chk(ticks == 0, "R1 after reset", ticks, 0);

    // Table walk: R3 R4 R5 R9
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, 16'(VEC[i][0]));
      wr(2'd1, 16'(VEC[i][1]));
      wr(2'd2, 16'h0);
      chk(!cfgError, "R8 legal", cfgError, 0);
      runRate(VEC[i][0], VEC[i][1], VEC[i][2]);
    end

    // R2: shadow writes leave a running 3.0 rate untouched
    wr(2'd0, 16'd3); wr(2'd1, 16'd0); wr(2'd2, 16'h0);
    wr(2'd0, 16'd7); wr(2'd1, 16'd9);
    ticks = 0; prevT = 0; badIv = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (overTick) begin
        if (ticks > 0 && c - prevT != 3) badIv++;
        ticks++; prevT = c;
      end
    end
    chk(badIv == 0 && ticks >= 12, "R2 shadow no effect", badIv, 0);
    wr(2'd2, 16'h0);
    runRate(7, 9, 457);

    // R6: upper data bits of the fraction write are dropped
    wr(2'd0, 16'd3); wr(2'd1, 16'hFFC5); wr(2'd2, 16'h0);
    runRate(3, 5, 197);

    // R7: zero whole part
    wr(2'd0, 16'd0); wr(2'd1, 16'd4); wr(2'd2, 16'h0);
    ticks = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (overTick || bitTick) ticks++;
    end
    chk(cfgError, "R7 error flag", cfgError, 1);
    chk(ticks == 0, "R7 no ticks", ticks, 0);

    // R8: upper range bound
    wr(2'd0, 16'hFFFF); wr(2'd1, 16'd1); wr(2'd2, 16'h0);
    chk(cfgError, "R8 max plus fraction", cfgError, 1);
    wr(2'd1, 16'd0); wr(2'd2, 16'h0);
    chk(!cfgError, "R8 max exact", cfgError, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule